// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable, small-depth model of a synchronous SRAM. Read and write cycles can alternate on every clock with no idle cycle between them. Each rising edge registers the address, the three chip selects, the read/write select, the per-lane write enables and the advance/load control. A read returns its word combinationally in the cycle that follows the edge that loaded the address. A write takes its data one cycle after its address, and the array is updated on that later edge. Because the write lands on the same edge that loads the next command, a read issued right after a write to the same word already sees the new data.

Bursts of four words follow either a wrapping-increment order or an XOR order on the two low address bits. The block also models a clock-enable stall, deselected and no-op cycles, masking by byte lane, asynchronous output gating and a sleep input. There are no tristates. The bidirectional bus is split into an input bus, an output bus and an output-valid flag.

Top module: `flowthru_sram`

## Requirements
- R1: The device is selected only when a load edge (`advance`=0, `clk_en_n`=0) sees `cs1_n`=0, `cs2_n`=0 and `cs3`=1. Any other combination starts a deselected phase, and `dout_en` stays 0 in the next cycle.
- R2: On a load edge, `is_read`=1 starts a read and `is_read`=0 starts a write. On an advance edge (`advance`=1), `is_read` is ignored and the cycle type chosen at the load is kept.
- R3: After a read load edge at address A, `dout` equals the stored word at A in the following cycle, and `dout_en`=1 if `oe_n`=0.
- R4: Write data is taken from `din` at the enabled edge that ends the write phase. Lane k, which is bits [9k+8:9k], is stored only if `byte_we_n[k]`=0 was sampled with that phase's address or advance. With all four enables high, nothing is written.
- R5: Each enabled advance edge of an active burst moves to the next of four addresses, and the upper address bits stay fixed. With `burst_interleave`=0 the low two bits are (base + k) mod 4. With `burst_interleave`=1 they are base XOR k, where k is the beat number 0..3.
- R6: An edge with `clk_en_n`=1 changes no state and writes nothing. A read in progress keeps driving the same word, and a write in progress keeps `dout_en`=0.
- R7: A read loaded on the edge that takes a write's data, at that same address, returns the newly written data.
- R8: `dout_en` is 0 for the whole of any write phase, whatever `oe_n` is. `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock, so a read issued while `oe_n` is high drives nothing.
- R9: An advance edge while deselected keeps the device deselected.
- R10: While `sleep`=1, `dout_en` is 0, every other input is ignored and any pending operation is dropped. The array contents are retained. After sleep ends, the device stays deselected until a new load.
- R11: While `rst_n`=0, the device is deselected and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the edge |
| cs1_n | input | 1 | Active-low chip select |
| cs2_n | input | 1 | Second active-low chip select |
| cs3 | input | 1 | Active-high chip select |
| advance | input | 1 | 1 = advance burst, 0 = load new address |
| is_read | input | 1 | Cycle type at load: 1 read, 0 write |
| byte_we_n | input | LANES | Active-low write enable per 9-bit lane |
| addr | input | ADDR_W | Word address |
| burst_interleave | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| oe_n | input | 1 | Asynchronous active-low output gate |
| sleep | input | 1 | Low-power hold; ignores other inputs |
| din | input | LANES*LANE_W | Write data, one cycle after its address |
| dout | output | LANES*LANE_W | Read data |
| dout_en | output | 1 | High when `dout` would be driven |

## Verification
The assertions rely on one rule for the inputs: in the two enabled edges after `sleep` falls, no write may be loaded. The stimulus keeps to this rule by sending only deselect cycles after a sleep period. They also assume that `burst_interleave` changes only while the device is deselected, and the bench switches the burst order only after an idle deselect. Write data is always driven half a cycle before the edge that ends the write phase, so every late write sees a stable word.

// File: rtl/flowthru_sram.sv
`timescale 1ns/1ps
module flowthru_sram #(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      cs1_n,
  input  logic                      cs2_n,
  input  logic                      cs3,
  input  logic                      advance,
  input  logic                      is_read,
  input  logic [LANES-1:0]          byte_we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      burst_interleave,
  input  logic                      oe_n,
  input  logic                      sleep,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic               ph_valid;
  logic               ph_write;
  logic [ADDR_W-1:0]  ph_addr;
  logic [LANES-1:0]   ph_be_n;
  logic [BURST_W-1:0] burst_base;
  logic [BURST_W-1:0] burst_cnt;

  wire edge_ok  = !clk_en_n && !sleep;
  wire chip_sel = !cs1_n && !cs2_n && cs3;
  wire [BURST_W-1:0] cnt_nx = burst_cnt + BURST_W'(1);
  wire [BURST_W-1:0] low_nx = burst_interleave ? (burst_base ^ cnt_nx)
                                               : (burst_base + cnt_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_valid   <= 1'b0;
      ph_write   <= 1'b0;
      ph_addr    <= '0;
      ph_be_n    <= '1;
      burst_base <= '0;
      burst_cnt  <= '0;
    end else if (sleep) begin
      ph_valid <= 1'b0;
    end else if (!clk_en_n) begin
      if (!advance) begin
        ph_valid   <= chip_sel;
        ph_write   <= !is_read;
        ph_addr    <= addr;
        ph_be_n    <= byte_we_n;
        burst_base <= addr[BURST_W-1:0];
        burst_cnt  <= '0;
      end else if (ph_valid) begin
        burst_cnt <= cnt_nx;
        ph_addr   <= {ph_addr[ADDR_W-1:BURST_W], low_nx};
        ph_be_n   <= byte_we_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (edge_ok && ph_valid && ph_write) begin
      for (int l = 0; l < LANES; l++) begin
        if (!ph_be_n[l])
          mem[ph_addr][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
      end
    end
  end

  assign dout    = mem[ph_addr];
  assign dout_en = ph_valid && !ph_write && !oe_n && !sleep;
endmodule

// File: rtl/flowthru_sram_chk.sv
`timescale 1ns/1ps
module flowthru_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              cs1_n,
  input logic              cs2_n,
  input logic              cs3,
  input logic              advance,
  input logic              is_read,
  input logic              oe_n,
  input logic              sleep,
  input logic              dout_en,
  input logic              ph_valid,
  input logic [ADDR_W-1:0] ph_addr
);
  logic [1:0] wake_cnt;
  wire sel_in = !cs1_n && !cs2_n && cs3;
  wire ld_edge = !sleep && !clk_en_n && !advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wake_cnt <= 2'd0;
    else if (sleep)        wake_cnt <= 2'd2;
    else if (wake_cnt != 0) wake_cnt <= wake_cnt - 2'd1;
  end

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_edge && !sel_in) |=> !dout_en);

  // R8
  wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_edge && !is_read) |=> !dout_en);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep) |=> ($stable(ph_addr) && $stable(ph_valid)));

  // R9
  cont_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph_valid && advance) |=> !ph_valid);

  // R10
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  // R10
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !ph_valid);

  // R10
  wake_rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt != 0 && ld_edge && sel_in) |-> is_read);
endmodule

bind flowthru_sram flowthru_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n),
  .cs2_n(cs2_n), .cs3(cs3), .advance(advance), .is_read(is_read),
  .oe_n(oe_n), .sleep(sleep), .dout_en(dout_en), .ph_valid(ph_valid),
  .ph_addr(ph_addr)
);

// File: tb/tb_flowthru_sram.sv
`timescale 1ns/1ps
module tb_flowthru_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b0;
  logic        cs1_n = 1'b1, cs2_n = 1'b0, cs3 = 1'b1;
  logic        advance = 1'b0, is_read = 1'b1;
  logic [3:0]  byte_we_n = 4'hF;
  logic [7:0]  addr = '0;
  logic        burst_interleave = 1'b0;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_en;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  flowthru_sram dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n),
    .cs2_n(cs2_n), .cs3(cs3), .advance(advance), .is_read(is_read),
    .byte_we_n(byte_we_n), .addr(addr), .burst_interleave(burst_interleave),
    .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  typedef struct packed {
    logic        cen;
    logic [2:0]  cs;
    logic        adv;
    logic        rd;
    logic [3:0]  be;
    logic [7:0]  a;
    logic [35:0] d;
    logic        oe;
    logic        en;
    logic [35:0] q;
    logic [3:0]  req;
  } vec_t;

  // cs field = {cs1_n, cs2_n, cs3}; 3'b001 selects
  localparam vec_t TBL [24] = '{
    '{1'b0,3'b001,1'b0,1'b0,4'h0,8'h10,36'h0,        1'b0,1'b0,36'h0,        4'd2},
    '{1'b0,3'b001,1'b0,1'b0,4'h0,8'h11,36'hFFFFFFFFF,1'b0,1'b0,36'h0,        4'd2},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h11,36'h222222222,1'b0,1'b1,36'h222222222,4'd7},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h10,36'h0,        1'b0,1'b1,36'hFFFFFFFFF,4'd3},
    '{1'b0,3'b001,1'b0,1'b0,4'hA,8'h10,36'h0,        1'b0,1'b0,36'h0,        4'd8},
    '{1'b0,3'b001,1'b0,1'b0,4'hF,8'h11,36'h0,        1'b0,1'b0,36'h0,        4'd8},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h10,36'h0,        1'b0,1'b1,36'hFF803FE00,4'd4},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h11,36'h0,        1'b0,1'b1,36'h222222222,4'd4},
    '{1'b1,3'b001,1'b0,1'b0,4'h0,8'h10,36'h0,        1'b0,1'b1,36'h222222222,4'd6},
    '{1'b0,3'b101,1'b0,1'b0,4'h0,8'h10,36'h0,        1'b0,1'b0,36'h0,        4'd1},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h10,36'h0,        1'b0,1'b0,36'h0,        4'd9},
    '{1'b0,3'b011,1'b0,1'b1,4'h0,8'h10,36'h0,        1'b0,1'b0,36'h0,        4'd1},
    '{1'b0,3'b000,1'b0,1'b1,4'h0,8'h10,36'h0,        1'b0,1'b0,36'h0,        4'd1},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h10,36'h0,        1'b1,1'b0,36'h0,        4'd8},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h10,36'h0,        1'b0,1'b1,36'hFF803FE00,4'd3},
    '{1'b0,3'b001,1'b0,1'b0,4'h0,8'h22,36'h0,        1'b0,1'b0,36'h0,        4'd2},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h22,36'h1,        1'b0,1'b0,36'h0,        4'd2},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h22,36'h2,        1'b0,1'b0,36'h0,        4'd5},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h22,36'h3,        1'b0,1'b0,36'h0,        4'd5},
    '{1'b0,3'b001,1'b0,1'b1,4'h0,8'h21,36'h4,        1'b0,1'b1,36'h4,        4'd7},
    '{1'b0,3'b001,1'b1,1'b0,4'h0,8'h21,36'h0,        1'b0,1'b1,36'h1,        4'd2},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h21,36'h0,        1'b0,1'b1,36'h2,        4'd5},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h21,36'h0,        1'b0,1'b1,36'h3,        4'd5},
    '{1'b0,3'b001,1'b1,1'b1,4'h0,8'h21,36'h0,        1'b0,1'b1,36'h4,        4'd5}
  };

  task automatic step(input logic cen, input logic [2:0] cs, input logic adv,
                      input logic rd, input logic [3:0] be, input logic [7:0] a,
                      input logic [35:0] d, input logic o, input logic s);
    @(negedge clk);
    clk_en_n = cen; {cs1_n, cs2_n, cs3} = cs; advance = adv; is_read = rd;
    byte_we_n = be; addr = a; din = d; oe_n = o; sleep = s;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic en_exp, input logic [35:0] q_exp,
                     input int req, input string what);
    tests++;
    if (dout_en !== en_exp || (en_exp && dout !== q_exp)) begin
      fails++;
      $display("FAIL R%0d %s: dout_en=%0b dout=%h, expected dout_en=%0b dout=%h",
               req, what, dout_en, dout, en_exp, q_exp);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #1 chk(1'b0, '0, 11, "in reset");
    @(negedge clk) rst_n = 1'b1;
    step(1'b0, 3'b101, 1'b0, 1'b1, 4'hF, 8'h0, '0, 1'b0, 1'b0);
    chk(1'b0, '0, 11, "after reset");

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: vector table
    for (int i = 0; i < 24; i++) begin
      step(TBL[i].cen, TBL[i].cs, TBL[i].adv, TBL[i].rd, TBL[i].be,
           TBL[i].a, TBL[i].d, TBL[i].oe, 1'b0);
      chk(TBL[i].en, TBL[i].q, int'(TBL[i].req), $sformatf("vector %0d", i));
    end

    // R8: asynchronous output gate during an active read
    #0.5 oe_n = 1'b1;
    #0.5 chk(1'b0, '0, 8, "oe_n high mid-read");
    oe_n = 1'b0;
    #0.5 chk(1'b1, 36'h4, 8, "oe_n low again");

    // R6: stall during a write phase, data taken only on enabled edge
    step(1'b0, 3'b001, 1'b0, 1'b0, 4'h0, 8'h30, '0, 1'b0, 1'b0);
    step(1'b1, 3'b001, 1'b0, 1'b1, 4'h0, 8'h55, 36'hAAAAAAAAA, 1'b0, 1'b0);
    chk(1'b0, '0, 6, "stalled write stays off bus");
    step(1'b0, 3'b001, 1'b0, 1'b1, 4'h0, 8'h30, 36'h5, 1'b0, 1'b0);
    chk(1'b1, 36'h5, 6, "write after stall");

    // R5: XOR burst order, mode switched while deselected
    step(1'b0, 3'b101, 1'b0, 1'b1, 4'hF, 8'h0, '0, 1'b0, 1'b0);
    burst_interleave = 1'b1;
    step(1'b0, 3'b001, 1'b0, 1'b0, 4'h0, 8'h41, '0, 1'b0, 1'b0);
    step(1'b0, 3'b001, 1'b1, 1'b1, 4'h0, 8'h0, 36'h41, 1'b0, 1'b0);
    step(1'b0, 3'b001, 1'b1, 1'b1, 4'h0, 8'h0, 36'h40, 1'b0, 1'b0);
    step(1'b0, 3'b001, 1'b1, 1'b1, 4'h0, 8'h0, 36'h43, 1'b0, 1'b0);
    step(1'b0, 3'b001, 1'b0, 1'b1, 4'h0, 8'h42, 36'h42, 1'b0, 1'b0);
    chk(1'b1, 36'h42, 5, "xor burst beat0");
    step(1'b0, 3'b001, 1'b1, 1'b1, 4'h0, 8'h0, '0, 1'b0, 1'b0);
    chk(1'b1, 36'h43, 5, "xor burst beat1");
    step(1'b0, 3'b001, 1'b1, 1'b1, 4'h0, 8'h0, '0, 1'b0, 1'b0);
    chk(1'b1, 36'h40, 5, "xor burst beat2");
    step(1'b0, 3'b001, 1'b1, 1'b1, 4'h0, 8'h0, '0, 1'b0, 1'b0);
    chk(1'b1, 36'h41, 5, "xor burst beat3");

    // R10: sleep
    #0.5 sleep = 1'b1;
    #0.5 chk(1'b0, '0, 10, "sleep forces bus off");
    step(1'b0, 3'b001, 1'b0, 1'b0, 4'h0, 8'h41, '0, 1'b0, 1'b1);
    step(1'b0, 3'b001, 1'b0, 1'b1, 4'h0, 8'h41, '0, 1'b0, 1'b1);
    chk(1'b0, '0, 10, "inputs ignored in sleep");
    step(1'b0, 3'b101, 1'b0, 1'b1, 4'hF, 8'h0, '0, 1'b0, 1'b0);
    chk(1'b0, '0, 10, "deselected after wake");
    step(1'b0, 3'b101, 1'b0, 1'b1, 4'hF, 8'h0, '0, 1'b0, 1'b0);
    step(1'b0, 3'b001, 1'b0, 1'b1, 4'h0, 8'h41, '0, 1'b0, 1'b0);
    chk(1'b1, 36'h41, 10, "array kept through sleep");

    // R11: asynchronous reset mid-read
    #0.5 rst_n = 1'b0;
    #0.5 chk(1'b0, '0, 11, "reset during read");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule